// File: doc/BRIEF.md
# Synchronized Bitstream Input Sampler

This block takes a serial ones-density bitstream from outside the chip and samples it once every 16 master clock cycles. A rising edge on the synchronization input realigns the sampling phase to a known clock cycle. The bitstream source can therefore line its data up to a known time reference and get an output with a repeatable phase.

Each sampled bit appears at the output a fixed four cycles after it was taken, with a one-cycle valid strobe. The block also keeps a signed running estimate of the ones-density over the last 64 samples. On that scale 50% reads as zero, 75% as positive full scale and 25% as negative full scale. A settled flag rises a fixed 400 cycles after each synchronization. While data mode is disabled the block holds all of its state cleared and keeps its outputs inactive.

Top module: `ones_stream_sampler`

## Requirements
- R1: With the sync input held steady, consecutive `smp_valid_o` pulses are exactly 16 cycles apart and each lasts one cycle.
- R2: After reset release, or after `data_en_i` goes high, call the first clock edge with the block enabled E1. The phase counter starts from zero there, the first sample is taken at edge E1+15, and its valid pulse is visible after edge E1+19.
- R3: A sync rising edge is accepted at the clock edge E0 where `sync_i` is first sampled high. The next sample is taken at edge E0+8, and sampling then repeats every 16 edges.
- R4: At an accepted sync edge E0, samples still in flight are dropped and the density estimate is cleared to 0. No valid pulse appears until the one for the E0+8 sample, which is visible after edge E0+12.
- R5: A sync rising edge is accepted only if `sync_i` was sampled low on at least the 2 preceding edges. A high that follows a 1-cycle low pulse has no effect on the sampling phase or on the density estimate.
- R6: A bit sampled from `stream_i` at edge S appears on `smp_bit_o` together with `smp_valid_o` after edge S+4.
- R7: Let ones be the number of 1 bits among the last 64 samples. `density_o` is then the signed 16-bit value (ones-32)*32767/16, truncated toward zero and clamped to +32767 for ones>=48 and to -32767 for ones<=16. It updates in the same cycle as the valid pulse of the newest sample.
- R8: `settled_o` is low after a sync edge E0 up to and including edge E0+399, and high from edge E0+400 on, until the next accepted sync.
- R9: While `data_en_i` is low, `smp_valid_o`, `smp_bit_o` and `settled_o` are 0 and `density_o` is 0. The same holds during reset.
- R10: Holding `sync_i` steadily high does not disturb sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_en_i | input | 1 | Enables data mode; low clears all state |
| sync_i | input | 1 | Synchronization input; its qualified rising edge realigns the phase |
| stream_i | input | 1 | External ones-density bitstream |
| smp_bit_o | output | 1 | Sampled bit, delayed by the fixed latency |
| smp_valid_o | output | 1 | One-cycle strobe qualifying smp_bit_o |
| density_o | output | 16 | Signed ones-density estimate |
| settled_o | output | 1 | High once 400 cycles have passed since the last sync |

## Verification
The bench feeds bitstream patterns that were aligned by a sync edge and checks every output strobe at its exact cycle. A design with an off-by-one phase load, or with the wrong pipeline depth, shows up as a missing or misplaced pulse. Density checks use 25%, 37.5%, 50%, 62.5%, 75%, 87.5% and 0% patterns, which cover exact full scale, the clamp and truncation toward zero for negative values. A single-cycle low glitch on sync must leave the phase untouched; a design that accepted it would shift every later pulse. The bench also confirms that in-flight samples vanish at sync, that the settled flag rises on exactly the 400th edge, and that re-enabling restarts the phase from zero.

// File: rtl/bss_pkg.sv
package bss_pkg;
  localparam int unsigned DEF_PERIOD  = 16;
  localparam int unsigned DEF_OFFSET  = 8;
  localparam int unsigned DEF_LATENCY = 4;
  localparam int unsigned DEF_MIN_LOW = 2;
  localparam int unsigned DEF_WIN     = 64;
  localparam int unsigned DEF_SETTLE  = 400;
  localparam int unsigned DEF_OUT_W   = 16;

  // ones in window -> signed level, 25%..75% span, truncated toward zero
  function automatic int level_of(int ones, int win, int fs);
    int d;
    int q;
    d = ones - win / 2;
    q = win / 4;
    if (d >= q) return fs;
    if (d <= -q) return -fs;
    return (d * fs) / q;
  endfunction
endpackage

// File: rtl/bss_sync_qual.sv
module bss_sync_qual #(
  parameter int unsigned MIN_LOW = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sync_i,
  output logic hit_o
);
  localparam int unsigned LW = $clog2(MIN_LOW + 1);

  logic [LW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
    end else if (!en_i || sync_i) begin
      low_cnt_q <= '0;
    end else if (low_cnt_q < LW'(MIN_LOW)) begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assign hit_o = en_i && sync_i && (low_cnt_q >= LW'(MIN_LOW));
endmodule

// File: rtl/bss_phase_gen.sv
module bss_phase_gen #(
  parameter int unsigned PERIOD = 16,
  parameter int unsigned OFFSET = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hit_i,
  output logic strobe_o
);
  localparam int unsigned PW = $clog2(PERIOD);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);
  localparam logic [PW-1:0] LOAD = PW'(PERIOD - OFFSET);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (hit_i) begin
      cnt_q <= LOAD;  // strobe lands OFFSET edges after the sync edge
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign strobe_o = en_i && !hit_i && (cnt_q == LAST);
endmodule

// File: rtl/bss_lat_pipe.sv
module bss_lat_pipe #(
  parameter int unsigned LATENCY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic strobe_i,
  input  logic bit_i,
  output logic pre_valid_o,
  output logic pre_bit_o,
  output logic valid_o,
  output logic bit_o
);
  logic [LATENCY:0] v_q;
  logic [LATENCY:0] b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q[0] <= 1'b0;
      b_q[0] <= 1'b0;
    end else if (flush_i) begin
      v_q[0] <= 1'b0;
      b_q[0] <= 1'b0;
    end else begin
      v_q[0] <= strobe_i;
      b_q[0] <= strobe_i & bit_i;
    end
  end

  for (genvar g = 1; g <= LATENCY; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[g] <= 1'b0;
        b_q[g] <= 1'b0;
      end else if (flush_i) begin
        v_q[g] <= 1'b0;
        b_q[g] <= 1'b0;
      end else begin
        v_q[g] <= v_q[g-1];
        b_q[g] <= b_q[g-1];
      end
    end
  end

  assign pre_valid_o = v_q[LATENCY-1];
  assign pre_bit_o   = b_q[LATENCY-1];
  assign valid_o     = v_q[LATENCY];
  assign bit_o       = b_q[LATENCY];
endmodule

// File: rtl/bss_density_est.sv
module bss_density_est
  import bss_pkg::*;
#(
  parameter int unsigned WIN   = 64,
  parameter int unsigned OUT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    push_i,
  input  logic                    bit_i,
  output logic signed [OUT_W-1:0] level_o
);
  localparam int unsigned CW = $clog2(WIN + 1);
  localparam int FS = (2 ** (OUT_W - 1)) - 1;
  localparam logic [WIN-1:0] NEUTRAL = {(WIN / 2){2'b01}};

  logic [WIN-1:0]          win_q;
  logic [CW-1:0]           ones_q;
  logic signed [OUT_W-1:0] level_q;
  int                      ones_nxt;

  always_comb begin
    ones_nxt = int'(ones_q) + int'(bit_i) - int'(win_q[WIN-1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= NEUTRAL;
      ones_q  <= CW'(WIN / 2);
      level_q <= '0;
    end else if (clear_i) begin
      win_q   <= NEUTRAL;  // half ones: estimate restarts at zero
      ones_q  <= CW'(WIN / 2);
      level_q <= '0;
    end else if (push_i) begin
      win_q   <= {win_q[WIN-2:0], bit_i};
      ones_q  <= CW'(ones_nxt);
      level_q <= OUT_W'(level_of(ones_nxt, int'(WIN), FS));
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/ones_stream_sampler.sv
module ones_stream_sampler
  import bss_pkg::*;
#(
  parameter int unsigned PERIOD  = DEF_PERIOD,
  parameter int unsigned OFFSET  = DEF_OFFSET,
  parameter int unsigned LATENCY = DEF_LATENCY,
  parameter int unsigned MIN_LOW = DEF_MIN_LOW,
  parameter int unsigned WIN     = DEF_WIN,
  parameter int unsigned SETTLE  = DEF_SETTLE,
  parameter int unsigned OUT_W   = DEF_OUT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    data_en_i,
  input  logic                    sync_i,
  input  logic                    stream_i,
  output logic                    smp_bit_o,
  output logic                    smp_valid_o,
  output logic signed [OUT_W-1:0] density_o,
  output logic                    settled_o
);
  localparam int unsigned SW = $clog2(SETTLE + 1);

  logic          sync_hit;
  logic          strobe;
  logic          clear;
  logic          pre_valid;
  logic          pre_bit;
  logic [SW-1:0] settle_q;

  assign clear = !data_en_i || sync_hit;

  bss_sync_qual #(.MIN_LOW(MIN_LOW)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (data_en_i),
    .sync_i (sync_i),
    .hit_o  (sync_hit)
  );

  bss_phase_gen #(.PERIOD(PERIOD), .OFFSET(OFFSET)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (data_en_i),
    .hit_i    (sync_hit),
    .strobe_o (strobe)
  );

  bss_lat_pipe #(.LATENCY(LATENCY)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (clear),
    .strobe_i    (strobe),
    .bit_i       (stream_i),
    .pre_valid_o (pre_valid),
    .pre_bit_o   (pre_bit),
    .valid_o     (smp_valid_o),
    .bit_o       (smp_bit_o)
  );

  // fed from the stage before the output so level moves with the valid pulse
  bss_density_est #(.WIN(WIN), .OUT_W(OUT_W)) u_dens (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .push_i  (pre_valid),
    .bit_i   (pre_bit),
    .level_o (density_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_q <= '0;
    end else if (clear) begin
      settle_q <= '0;
    end else if (settle_q < SW'(SETTLE)) begin
      settle_q <= settle_q + 1'b1;
    end
  end

  assign settled_o = (settle_q == SW'(SETTLE));
endmodule

// File: rtl/bss_sampler_chk.sv
module bss_sampler_chk #(
  parameter int unsigned OUT_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    data_en_i,
  input logic                    sync_i,
  input logic                    hit_i,
  input logic                    smp_valid_o,
  input logic signed [OUT_W-1:0] density_o,
  input logic                    settled_o
);
  localparam int FS = (2 ** (OUT_W - 1)) - 1;

  // R1: single-cycle valid pulses
  a_r1_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |=> !smp_valid_o);

  // R4: sync clears estimate, drops in-flight samples
  a_r4_sync_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> (density_o == '0) && !smp_valid_o && !settled_o);

  // R5: accepted edge needs two prior low samples
  a_r5_min_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> ($past(!sync_i, 1) && $past(!sync_i, 2)));

  // R7: estimate stays inside symmetric full scale
  a_r7_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(density_o) <= FS) && (int'(density_o) >= -FS));

  // R9: disabled means inactive outputs
  a_r9_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_en_i |=> !smp_valid_o && (density_o == '0) && !settled_o);
endmodule

bind ones_stream_sampler bss_sampler_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .data_en_i   (data_en_i),
  .sync_i      (sync_i),
  .hit_i       (sync_hit),
  .smp_valid_o (smp_valid_o),
  .density_o   (density_o),
  .settled_o   (settled_o)
);

// File: tb/tb_ones_stream_sampler.sv
`timescale 1ns/1ps
module tb_ones_stream_sampler;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        data_en_i;
  logic        sync_i;
  logic        stream_i;
  logic        smp_bit_o;
  logic        smp_valid_o;
  logic signed [15:0] density_o;
  logic        settled_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  ones_stream_sampler dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .data_en_i   (data_en_i),
    .sync_i      (sync_i),
    .stream_i    (stream_i),
    .smp_bit_o   (smp_bit_o),
    .smp_valid_o (smp_valid_o),
    .density_o   (density_o),
    .settled_o   (settled_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_level(input int ones);
    int d;
    d = ones - 32;
    if (d >= 16) return 32767;
    if (d <= -16) return -32767;
    return (d * 32767) / 16;
  endfunction

  // leaves the bench at negedge N0; the next posedge is the sync edge E0
  task automatic do_sync();
    sync_i = 1'b0;
    tick(2);
    sync_i = 1'b1;
  endtask

  task automatic feed(input logic [7:0] pat, input int len, input int glitch_k, input string tag);
    int ones;
    ones = 0;
    do_sync();
    stream_i = pat[0];
    tick(1);
    chk(density_o == 16'sd0, {tag, " R4 density cleared"}, int'(density_o), 0);
    chk(!settled_o, {tag, " R8 settled low after sync"}, int'(settled_o), 0);
    tick(11);
    chk(!smp_valid_o, {tag, " R4 no valid before E0+12"}, int'(smp_valid_o), 0);
    for (int k = 0; k < 64; k++) begin
      if (k > 0) begin
        stream_i = pat[k % len];
        if (k == glitch_k) begin
          tick(3);
          sync_i = 1'b0;
          tick(1);
          sync_i = 1'b1;
          tick(9);
        end else begin
          tick(13);
        end
      end else begin
        tick(1);
      end
      ones += int'(pat[k % len]);
      chk(smp_valid_o, {tag, (k == glitch_k + 1) ? " R5 phase kept" : " R3/R6 valid at sample+4"},
          int'(smp_valid_o), 1);
      chk(smp_bit_o == pat[k % len], {tag, " R6 bit value"}, int'(smp_bit_o), int'(pat[k % len]));
      tick(1);
      chk(!smp_valid_o, {tag, " R1 single-cycle valid"}, int'(smp_valid_o), 0);
      tick(2);
    end
    chk(int'(density_o) == exp_level(ones), {tag, " R7 density"}, int'(density_o), exp_level(ones));
    chk(settled_o, {tag, " R8 settled after long run"}, int'(settled_o), 1);
  endtask

  task automatic test_reset_phase();
    // reset held; R9 reset state
    tick(3);
    chk(!smp_valid_o && !smp_bit_o && !settled_o && density_o == 16'sd0,
        "R9 reset state", int'(smp_valid_o), 0);
    rst_ni = 1'b1;
    tick(19);
    chk(!smp_valid_o, "R2 no valid before E1+19", int'(smp_valid_o), 0);
    tick(1);
    chk(smp_valid_o && smp_bit_o, "R2 first sample after reset", int'(smp_valid_o), 1);
    tick(16);
    chk(smp_valid_o, "R1 next sample 16 later", int'(smp_valid_o), 1);
  endtask

  task automatic test_settle();
    do_sync();
    tick(400);
    chk(!settled_o, "R8 low through E0+399", int'(settled_o), 0);
    tick(1);
    chk(settled_o, "R8 high after E0+400", int'(settled_o), 1);
  endtask

  task automatic test_disable();
    bit seen;
    seen = 1'b0;
    stream_i = 1'b1;
    data_en_i = 1'b0;
    for (int i = 0; i < 30; i++) begin
      tick(1);
      if (smp_valid_o || smp_bit_o || settled_o || density_o != 16'sd0) seen = 1'b1;
    end
    chk(!seen, "R9 outputs idle while disabled", int'(seen), 0);
    data_en_i = 1'b1;  // sync held high: R10 no spurious edge
    tick(19);
    chk(!smp_valid_o, "R2 no valid before E1+19 after enable", int'(smp_valid_o), 0);
    tick(1);
    chk(smp_valid_o && smp_bit_o, "R2 first sample after enable", int'(smp_valid_o), 1);
    tick(16);
    chk(smp_valid_o, "R10 sampling continues with sync high", int'(smp_valid_o), 1);
  endtask

  initial begin
    rst_ni    = 1'b0;
    data_en_i = 1'b1;
    sync_i    = 1'b0;
    stream_i  = 1'b1;
    test_reset_phase();
    feed(8'b0000_0111, 4, -1, "p75");
    feed(8'b0000_0001, 4, -1, "p25");
    feed(8'b0000_0001, 2, -1, "p50");
    feed(8'b1101_1010, 8, 10, "p62");
    feed(8'b1010_0100, 8, -1, "p37");
    feed(8'b0111_1111, 8, -1, "p87");
    feed(8'b0000_0000, 1, -1, "p0");
    test_settle();
    test_disable();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule